// File: doc/BRIEF.md
# Port-Triggered Arithmetic Unit

This block is an arithmetic function unit for a processor whose instructions only move data between ports. It has one write channel and one result output. A write to the operand port only stores a value. A write to any other port starts the operation that belongs to that port. The stored operand is the first input and the written word is the second input. The result register always shows the most recent completed result.

The unit has no hazard detection, no stall signal and no valid flag. Software has to read each result inside its window. That window opens when the operation's latency has passed. It closes when a later operation completes and overwrites the result.

Single-cycle operations (add, subtract, and, or, xor) finish one clock after the trigger. The multiply is fully pipelined and takes `MUL_LAT` clocks, so a new operation can start on every clock.

Top module: `trig_alu_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `result` reads zero until the first operation completes.
- R2: A write with port code 0 stores `wrData` as the operand. It leaves `result` unchanged.
- R3: A trigger uses the stored operand as its first input and `wrData` as its second. Subtract computes operand minus `wrData`.
- R4: Port codes 1, 2, 3, 4 and 5 select add, subtract, and, or and xor. Each result, taken modulo 2^WIDTH, appears on `result` in the cycle after the trigger.
- R5: Port code 6 selects multiply. The low WIDTH bits of the product appear on `result` MUL_LAT cycles after the trigger, which is the third cycle for the default value.
- R6: If `result` is read before an operation's latency has passed, it returns the previously completed result.
- R7: A multiply can be triggered on every cycle. Back-to-back multiplies complete on consecutive cycles, in trigger order.
- R8: If a single-cycle operation and an earlier multiply complete in the same cycle, the single-cycle (later-triggered) result is written to `result`.
- R9: `result` holds its value until the next completion. Cycles with `wrEn` low, and writes with port code 7, change nothing.
- R10: The stored operand stays unchanged across triggers until the next port-0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | A move targets this unit this cycle |
| portSel | input | 3 | Destination port code (see R2, R4, R5, R9) |
| wrData | input | WIDTH | Data carried by the move |
| result | output | WIDTH | Result port |

## Verification
The bench builds the unit with its defaults: WIDTH 16 and MUL_LAT 3. With 16 bits, hand-computable values can exercise carry-out wrap on add, borrow on subtract, and truncation of a product whose only set bit is bit 16. With a three-cycle multiply, the early-read window, back-to-back issue and a same-cycle collision with an add can all be reached with short directed sequences. The stimulus is applied at the falling edge, and the checks are timed from the trigger edge.

// File: rtl/trig_alu_pkg.sv
package trig_alu_pkg;

  typedef enum logic [2:0] {
    PORT_OPND = 3'd0,
    PORT_ADD  = 3'd1,
    PORT_SUB  = 3'd2,
    PORT_AND  = 3'd3,
    PORT_OR   = 3'd4,
    PORT_XOR  = 3'd5,
    PORT_MUL  = 3'd6,
    PORT_NONE = 3'd7
  } port_e;

  typedef enum logic [2:0] {
    FOP_ADD = 3'd0,
    FOP_SUB = 3'd1,
    FOP_AND = 3'd2,
    FOP_OR  = 3'd3,
    FOP_XOR = 3'd4
  } fast_op_e;

  typedef struct packed {
    logic     opLatch;
    logic     fastGo;
    fast_op_e fastOp;
    logic     mulGo;
  } strobe_t;

endpackage

// File: rtl/trig_alu_ctrl.sv
module trig_alu_ctrl
  import trig_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] portSel,
  output strobe_t    stb
);

  always_comb begin
    stb        = '0;
    stb.fastOp = FOP_ADD;
    if (wrEn) begin
      unique case (port_e'(portSel))
        PORT_OPND: stb.opLatch = 1'b1;
        PORT_ADD:  begin stb.fastGo = 1'b1; stb.fastOp = FOP_ADD; end
        PORT_SUB:  begin stb.fastGo = 1'b1; stb.fastOp = FOP_SUB; end
        PORT_AND:  begin stb.fastGo = 1'b1; stb.fastOp = FOP_AND; end
        PORT_OR:   begin stb.fastGo = 1'b1; stb.fastOp = FOP_OR;  end
        PORT_XOR:  begin stb.fastGo = 1'b1; stb.fastOp = FOP_XOR; end
        PORT_MUL:  stb.mulGo = 1'b1;
        default:   ;
      endcase
    end
  end

  // R9: at most one action per move; an idle cycle or port 7 triggers nothing
  assert_one_action_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.opLatch, stb.fastGo, stb.mulGo}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || portSel == 3'd7) |-> (stb.opLatch == 1'b0 && stb.fastGo == 1'b0 && stb.mulGo == 1'b0));

endmodule

// File: rtl/trig_alu_dpath.sv
module trig_alu_dpath
  import trig_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MUL_LAT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] result
);

  localparam int LAST = MUL_LAT - 2;

  logic [WIDTH-1:0] operandQ;
  logic [WIDTH-1:0] fastVal;
  logic [WIDTH-1:0] mulA, mulB;
  logic [WIDTH-1:0] prodQ [1:LAST];
  logic             vldQ  [0:LAST];
  logic [WIDTH-1:0] prodNext;
  logic             mulLast;

  initial begin
    if (MUL_LAT < 3) $error("MUL_LAT must be at least 3");
  end

  always_ff @(posedge clk) begin
    if (!rstN)            operandQ <= '0;
    else if (stb.opLatch) operandQ <= wrData;
  end

  always_comb begin
    unique case (stb.fastOp)
      FOP_ADD: fastVal = operandQ + wrData;
      FOP_SUB: fastVal = operandQ - wrData;
      FOP_AND: fastVal = operandQ & wrData;
      FOP_OR:  fastVal = operandQ | wrData;
      FOP_XOR: fastVal = operandQ ^ wrData;
      default: fastVal = '0;
    endcase
  end

  // multiply stage 0: capture inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulA    <= '0;
      mulB    <= '0;
      vldQ[0] <= 1'b0;
    end else begin
      vldQ[0] <= stb.mulGo;
      if (stb.mulGo) begin
        mulA <= operandQ;
        mulB <= wrData;
      end
    end
  end

  assign prodNext = mulA * mulB;

  // multiply stage 1: product register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ[1] <= '0;
      vldQ[1]  <= 1'b0;
    end else begin
      prodQ[1] <= prodNext;
      vldQ[1]  <= vldQ[0];
    end
  end

  // extra delay stages for MUL_LAT above three
  for (genvar s = 2; s <= LAST; s++) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodQ[s] <= '0;
        vldQ[s]  <= 1'b0;
      end else begin
        prodQ[s] <= prodQ[s-1];
        vldQ[s]  <= vldQ[s-1];
      end
    end
  end

  assign mulLast = vldQ[LAST];

  // later-triggered single-cycle op wins a shared completion slot
  always_ff @(posedge clk) begin
    if (!rstN)           result <= '0;
    else if (stb.fastGo) result <= fastVal;
    else if (mulLast)    result <= prodQ[LAST];
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (result == '0));

  assert_no_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.fastGo && !mulLast) |=> $stable(result));

  assert_add_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fastGo && stb.fastOp == FOP_ADD) |=> (result == $past(operandQ + wrData)));

  assert_sub_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fastGo && stb.fastOp == FOP_SUB) |=> (result == $past(operandQ - wrData)));

  assert_fast_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fastGo && mulLast) |=> (result == $past(fastVal)));

  if (MUL_LAT == 3) begin : g_mul_chk
    logic [2:0] sinceRst;
    always_ff @(posedge clk) begin
      if (!rstN)              sinceRst <= '0;
      else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
    end
    assert_mul_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 3'd3 && $past(stb.mulGo, 2) && !stb.fastGo)
      |=> (result == $past(mulA * mulB, 2)));
  end

endmodule

// File: rtl/trig_alu_unit.sv
module trig_alu_unit
  import trig_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MUL_LAT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       portSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] result
);

  strobe_t stb;

  trig_alu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .portSel (portSel),
    .stb     (stb)
  );

  trig_alu_dpath #(
    .WIDTH   (WIDTH),
    .MUL_LAT (MUL_LAT)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .result (result)
  );

endmodule

// File: tb/trig_alu_unit_bench.sv
module trig_alu_unit_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   portSel = 3'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trig_alu_unit #(.WIDTH(W), .MUL_LAT(3)) u_trig_alu_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .portSel(portSel),
    .wrData(wrData), .result(result)
  );

  // {operand, port, data, expected}
  localparam logic [50:0] VEC [6] = '{
    {16'h1234, 3'd1, 16'h1111, 16'h2345},
    {16'h0005, 3'd2, 16'h0007, 16'hFFFE},
    {16'hF0F0, 3'd3, 16'h3C3C, 16'h3030},
    {16'hF0F0, 3'd4, 16'h0F01, 16'hFFF1},
    {16'hAAAA, 3'd5, 16'hFFFF, 16'h5555},
    {16'hFFFF, 3'd1, 16'h0001, 16'h0000}
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  // drive one move at the falling edge, let a rising edge pass, return at the next falling edge
  task automatic move(input logic en, input logic [2:0] sel, input logic [W-1:0] d);
    wrEn = en; portSel = sel; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: result=%h expected=done", result);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0);
    rstN = 1'b1;
    move(1'b0, 3'd0, '0);
    check("R1", '0);

    // R3 R4: single-cycle ops via table
    for (int i = 0; i < 6; i++) begin
      move(1'b1, 3'd0, VEC[i][50:35]);
      move(1'b1, VEC[i][34:32], VEC[i][31:16]);
      check("R4", VEC[i][15:0]);
    end

    // R2: operand write leaves result (0000) alone
    move(1'b1, 3'd0, 16'h0003);
    check("R2", 16'h0000);

    // R5 R6: multiply latency
    move(1'b1, 3'd6, 16'h0005);
    check("R6", 16'h0000);
    move(1'b0, 3'd0, '0);
    check("R6", 16'h0000);
    move(1'b0, 3'd0, '0);
    check("R5", 16'h000F);

    // R7 R10: back-to-back, truncation
    move(1'b1, 3'd0, 16'h0100);
    move(1'b1, 3'd6, 16'h0002);
    move(1'b1, 3'd6, 16'h0003);
    move(1'b1, 3'd6, 16'h0100);
    check("R7", 16'h0200);
    move(1'b0, 3'd0, '0);
    check("R7", 16'h0300);
    move(1'b0, 3'd0, '0);
    check("R5", 16'h0000);
    move(1'b1, 3'd1, 16'h0001);
    check("R10", 16'h0101);

    // R8: add lands on the same edge as an earlier multiply
    move(1'b1, 3'd0, 16'h0002);
    move(1'b1, 3'd6, 16'h0007);
    move(1'b0, 3'd0, '0);
    move(1'b1, 3'd1, 16'h0001);
    check("R8", 16'h0003);
    move(1'b0, 3'd0, '0);
    check("R8", 16'h0003);

    // R9: port 7 and idle cycles with a trigger code have no effect
    move(1'b1, 3'd7, 16'hBEEF);
    check("R9", 16'h0003);
    move(1'b0, 3'd1, 16'h1000);
    check("R9", 16'h0003);
    move(1'b1, 3'd1, 16'h0000);
    check("R9", 16'h0002);

    finish_run();
  end

endmodule